// File: doc/BRIEF.md
# Page-wrapping word address counter

This block holds the internal byte address of a paged serial memory. A bus front end loads a complete address, made of the upper address bits carried in the device word and the word-address byte, then steps the counter once per transferred byte. The counter keeps its value between transfers, so a later current-address read starts at the byte after the last one accessed.

Stepping behaves differently by direction. During a write only the in-page offset bits count, and the page row stays fixed, so a long burst wraps back to the first byte of the same page. During a read the whole address counts, and after the last byte of the array it returns to byte 0. The page size is 8 or 16 bytes, chosen by a configuration input. The array size is set at build time to 256, 512, 1024 or 2048 bytes through the address width.

Top module: `word_addr_ctr`

## Requirements
- R1: After reset the address output is 0.
- R2: When `load` is high at a clock edge, the address takes `load_addr` on that edge.
- R3: When `load` and `step` are both high, the load wins and the address equals `load_addr`.
- R4: With `step` high and `rd_mode` low (write), the offset bits advance by one modulo the page size. These are bits [2:0] when `page16` is 0 and bits [3:0] when `page16` is 1. All higher bits stay unchanged.
- R5: A write step from the last byte of a page (offset all ones) gives the first byte of the same page.
- R6: With `step` high and `rd_mode` high (read), the full address advances by one modulo 2^AW.
- R7: A read step from address 2^AW-1 gives address 0.
- R8: With neither `load` nor `step` high, the address holds its value across any number of cycles, whatever `rd_mode` and `page16` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load `load_addr` into the counter |
| load_addr | input | AW | Address to load |
| step | input | 1 | Advance by one byte |
| rd_mode | input | 1 | 1 = read (wrap over the array), 0 = write (wrap in the page) |
| page16 | input | 1 | 1 = 16-byte pages, 0 = 8-byte pages |
| addr | output | AW | Current address |

## Verification
The bench uses AW=8 and loads every one of the 256 addresses. From each address it takes one write step and one read step, under both page sizes, and compares the result with offset and row arithmetic. This separates in-page wrapping from array wrapping at every boundary, including the 8-byte boundaries that matter only for the small page. Long write bursts of 20 bytes check that the row never changes. A read sweep across address 255 checks the return to 0. Idle cycles with toggling mode inputs check the hold, and load together with step checks the priority.

// File: rtl/word_addr_ctr.sv
module word_addr_ctr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic          rd_mode,
  input  logic          page16,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] ofs_mask;
  logic [AW-1:0] inc_all;
  logic [AW-1:0] inc_page;
  logic [AW-1:0] nxt;

  assign ofs_mask = page16 ? AW'(15) : AW'(7);
  assign inc_all  = addr + ONE;
  assign inc_page = (addr & ~ofs_mask) | (inc_all & ofs_mask);
  assign nxt      = load ? load_addr
                  : step ? (rd_mode ? inc_all : inc_page)
                  : addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr <= '0;
    else        addr <= nxt;

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(load_addr));

  assert_row_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && !rd_mode) |=>
      ((addr & ~$past(ofs_mask)) == ($past(addr) & ~$past(ofs_mask))));

  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && !rd_mode && ((addr & ofs_mask) == ofs_mask)) |=>
      ((addr & $past(ofs_mask)) == '0));

  assert_array_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && rd_mode && (&addr)) |=> addr == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr));
endmodule

// File: tb/tb_word_addr_ctr.sv
module tb_word_addr_ctr;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0, load = 0, step = 0, rd_mode = 0, page16 = 0;
  logic [AW-1:0] load_addr = '0;
  logic [AW-1:0] addr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  word_addr_ctr #(.AW(AW)) dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] exp);
    n_chk++;
    if (addr !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, addr, exp);
    end
  endtask

  task automatic cyc(input logic l, input logic [AW-1:0] la, input logic s,
                     input logic rd, input logic p16);
    load = l; load_addr = la; step = s; rd_mode = rd; page16 = p16;
    @(posedge clk); #1;
    load = 0; step = 0;
  endtask

  function automatic logic [AW-1:0] wstep(input logic [AW-1:0] a, input logic p16);
    int ps = p16 ? 16 : 8;
    return AW'((a / ps) * ps + ((a % ps) + 1) % ps);
  endfunction

  initial begin
    #23; chk("R1", 0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      for (int p = 0; p < 2; p++) begin
        cyc(1, AW'(a), 0, 0, p[0]); chk("R2", AW'(a));
        cyc(0, 0, 1, 0, p[0]);      chk((a % (p ? 16 : 8)) == (p ? 15 : 7) ? "R5" : "R4", wstep(AW'(a), p[0]));
        cyc(1, AW'(a), 0, 1, p[0]);
        cyc(0, 0, 1, 1, p[0]);      chk(a == 255 ? "R7" : "R6", AW'((a + 1) % 256));
      end
    end
    for (int p = 0; p < 2; p++) begin
      logic [AW-1:0] e;
      e = 8'hA5;
      cyc(1, e, 0, 0, p[0]);
      for (int k = 0; k < 20; k++) begin
        cyc(0, 0, 1, 0, p[0]); e = wstep(e, p[0]); chk("R4", e);
      end
    end
    cyc(1, 8'd250, 0, 1, 0);
    for (int k = 0; k < 10; k++) begin
      cyc(0, 0, 1, 1, 0); chk("R6", AW'((251 + k) % 256));
    end
    cyc(1, 8'h3C, 1, 1, 1); chk("R3", 8'h3C);
    cyc(1, 8'h0F, 1, 0, 0); chk("R3", 8'h0F);
    for (int k = 0; k < 6; k++) begin
      cyc(0, 8'hFF, 0, k[0], k[1]); chk("R8", 8'h0F);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule